// File: doc/BRIEF.md
# Warp memory coalescing detector

This block sits between a warp's address-generation stage and a memory port. Each request carries one word address for each of the 32 threads of a warp, a 32-bit activity mask (threads switched off by predication have a 0 bit), and a flag that says whether the access reads or writes. The block checks whether the active threads touch a run of words that follows thread order. If they do, one contiguous transaction can serve the whole warp. If they do not, the access is a gather (for a read) or a scatter (for a write), and the block splits it into one transaction per active thread.

The reference word, called the base, is the address of the lowest active thread minus that thread's id. The request is contiguous when every active thread `t` addresses `base + t`. Address arithmetic wraps modulo 2^AW. The addresses of inactive threads are never looked at. Requests come in over a valid/ready pair. Transactions leave over a second valid/ready pair. The block holds one request at a time and takes no new request until every transaction of the current one has been taken downstream.

Top module: `warp_coalesce_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `txn_valid` is 0.
- R2: A request is classed as contiguous (`txn_whole`=1) exactly when every active thread t has address equal to base + t, where base is the lowest active thread's address minus its id, modulo 2^AW. Addresses of inactive threads have no effect on the class or on any transaction field.
- R3: A contiguous request produces exactly one transaction with `txn_whole`=1, `txn_addr`=base, `txn_mask`=the activity mask and `txn_tid`=the lowest active thread id.
- R4: A non-contiguous request produces one transaction per active thread, in ascending thread-id order. Each has `txn_whole`=0, `txn_addr`=that thread's address, `txn_tid`=its id, and `txn_mask` with only bit `txn_tid` set.
- R5: `txn_store` on every transaction of a request equals that request's `req_store` (1 = write/scatter, 0 = read/gather).
- R6: A request with an all-zero mask is accepted and produces no transaction, and `req_ready` is still 1 in the following cycle.
- R7: From the cycle after a request with a non-empty mask is accepted until the handshake of its last transaction, `req_ready` is 0. The first transaction is offered in the cycle after acceptance.
- R8: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid` and all transaction fields stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_store | input | 1 | 1 = write request, 0 = read request |
| req_mask | input | LANES | Per-thread activity mask, bit t for thread t |
| req_addr | input | LANES*AW | Word addresses, thread t in bits [t*AW +: AW] |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_whole | output | 1 | 1 = contiguous warp transaction, 0 = single thread |
| txn_store | output | 1 | Access kind of the owning request |
| txn_addr | output | AW | Base word address or thread word address |
| txn_mask | output | LANES | Activity mask, or one-hot thread bit |
| txn_tid | output | log2(LANES) | Lowest active thread id, or the serving thread id |

## Verification
The classifier is tried on a fully active run of ascending words, a sparse mask whose inactive threads carry junk addresses, and a base that wraps below zero. Together these show that only active threads are compared and that the base is derived from the lowest active thread. Near misses follow: a single wrong thread, a stride of four words, a descending run, and the two outermost threads alone. Each must fall back to per-thread transactions in ascending order. A lone highest thread must still count as contiguous. Empty masks, back-to-back requests and downstream stalls show that the block accepts nothing while busy and holds its outputs while stalled.

// File: rtl/wcu_pkg.sv
package wcu_pkg;
   typedef enum logic {
      WCU_IDLE = 1'b0,
      WCU_BUSY = 1'b1
   } wcu_state_e;
endpackage

// File: rtl/wcu_lowest.sv
module wcu_lowest #(
   parameter int N = 32,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("wcu_lowest: N must be at least 2");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/wcu_contig.sv
module wcu_contig #(
   parameter int LANES = 32,
   parameter int AW    = 32,
   localparam int TIDW = $clog2(LANES)
) (
   input  logic [LANES*AW-1:0] addr,
   input  logic [LANES-1:0]    mask,
   input  logic [TIDW-1:0]     low_idx,
   output logic [AW-1:0]       base,
   output logic                whole
);
   logic [LANES-1:0] lane_ok;
   logic [AW-1:0]    low_addr;

   assign low_addr = addr[low_idx*AW +: AW];
   assign base     = low_addr - AW'(low_idx);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [AW-1:0] want;
      assign want       = base + AW'(g);
      assign lane_ok[g] = ~mask[g] | (addr[g*AW +: AW] == want);
   end

   assign whole = &lane_ok;
endmodule

// File: rtl/wcu_sequencer.sv
module wcu_sequencer #(
   parameter int LANES = 32,
   localparam int TIDW = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [LANES-1:0] in_mask,
   input  logic             whole,
   input  logic [TIDW-1:0]  serve_idx,
   input  logic             txn_ready,
   output logic             busy,
   output logic             txn_valid,
   output logic [LANES-1:0] pend
);
   import wcu_pkg::*;

   wcu_state_e       state;
   logic             fire;
   logic [LANES-1:0] pend_next;

   assign busy      = (state == WCU_BUSY);
   assign txn_valid = busy;
   assign fire      = busy & txn_ready;
   assign pend_next = pend & ~(LANES'(1) << serve_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= WCU_IDLE;
         pend  <= '0;
      end else begin
         case (state)
            WCU_IDLE: begin
               if (accept && (|in_mask)) begin
                  state <= WCU_BUSY;
                  pend  <= in_mask;
               end
            end
            WCU_BUSY: begin
               if (fire) begin
                  if (whole || (pend_next == '0)) begin
                     state <= WCU_IDLE;
                     pend  <= '0;
                  end else begin
                     pend <= pend_next;
                  end
               end
            end
            default: state <= WCU_IDLE;
         endcase
      end
   end

   // R4: each per-thread handshake retires exactly one pending thread
   assert_retire_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !whole && (pend_next != '0)) |=>
         ($countones(pend) == $countones($past(pend)) - 1));
endmodule

// File: rtl/warp_coalesce_unit.sv
module warp_coalesce_unit #(
   parameter int LANES = 32,
   parameter int AW    = 32,
   localparam int TIDW = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_store,
   input  logic [LANES-1:0]    req_mask,
   input  logic [LANES*AW-1:0] req_addr,
   output logic                txn_valid,
   input  logic                txn_ready,
   output logic                txn_whole,
   output logic                txn_store,
   output logic [AW-1:0]       txn_addr,
   output logic [LANES-1:0]    txn_mask,
   output logic [TIDW-1:0]     txn_tid
);
   if (LANES < 2 || (1 << TIDW) != LANES) begin : g_bad_lanes
      $error("warp_coalesce_unit: LANES must be a power of two, at least 2");
   end
   if (AW < TIDW + 1) begin : g_bad_aw
      $error("warp_coalesce_unit: AW too narrow for LANES");
   end

   logic [LANES*AW-1:0] addr_q;
   logic [LANES-1:0]    mask_q;
   logic                store_q;
   logic                accept;
   logic                busy;
   logic [LANES-1:0]    pend;
   logic                low_found, serve_found;
   logic [TIDW-1:0]     low_idx, serve_idx;
   logic [AW-1:0]       base;
   logic                whole;

   assign req_ready = ~busy;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         mask_q  <= '0;
         store_q <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_addr;
         mask_q  <= req_mask;
         store_q <= req_store;
      end
   end

   wcu_lowest #(.N(LANES)) u_low_req (
      .vec(mask_q), .found(low_found), .idx(low_idx));

   wcu_lowest #(.N(LANES)) u_low_pend (
      .vec(pend), .found(serve_found), .idx(serve_idx));

   wcu_contig #(.LANES(LANES), .AW(AW)) u_contig (
      .addr(addr_q), .mask(mask_q), .low_idx(low_idx),
      .base(base), .whole(whole));

   wcu_sequencer #(.LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .in_mask(req_mask),
      .whole(whole), .serve_idx(serve_idx), .txn_ready(txn_ready),
      .busy(busy), .txn_valid(txn_valid), .pend(pend));

   assign txn_whole = whole;
   assign txn_store = store_q;
   assign txn_addr  = whole ? base : addr_q[serve_idx*AW +: AW];
   assign txn_mask  = whole ? mask_q : (LANES'(1) << serve_idx);
   assign txn_tid   = whole ? low_idx : serve_idx;

   // R1: idle and quiet in the first cycle out of reset
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (req_ready && !txn_valid));

   // R3: a contiguous transaction is the only one of its request
   assert_single_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_whole && txn_ready) |=> !txn_valid);

   // R4: a per-thread transaction names exactly its own active thread
   assert_onehot_thread_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_whole) |->
         (($countones(txn_mask) == 1) && txn_mask[txn_tid] && mask_q[txn_tid] && serve_found));

   // R6: an empty request leaves the block idle
   assert_empty_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_mask == '0)) |=> (req_ready && !txn_valid));

   // R7: first transaction follows acceptance, and no request is taken while stalled
   assert_offer_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (req_mask != '0)) |=> (txn_valid && !req_ready && low_found));
   assert_no_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> !req_ready);

   // R8: stalled outputs hold
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=>
         (txn_valid && $stable(txn_addr) && $stable(txn_mask) &&
          $stable(txn_tid) && $stable(txn_whole) && $stable(txn_store)));
endmodule

// File: tb/warp_coalesce_unit_bench.sv
`timescale 1ns/1ps
module warp_coalesce_unit_bench;
   localparam int LANES = 32;
   localparam int AW    = 32;

   typedef struct packed {
      logic        whole;
      logic        store;
      logic [31:0] addr;
      logic [31:0] mask;
      logic [4:0]  tid;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_store = 1'b0;
   logic [31:0]       req_mask = '0;
   logic [LANES*AW-1:0] req_addr = '0;
   logic              txn_valid;
   logic              txn_ready = 1'b1;
   logic              txn_whole, txn_store;
   logic [31:0]       txn_addr, txn_mask;
   logic [4:0]        txn_tid;

   int   errs = 0;
   int   chks = 0;
   int   pushed = 0;
   int   popped = 0;
   bit   bp_on = 1'b0;
   int   cyc = 0;
   exp_t q[$];
   logic [31:0] av [32];

   always #2 clk = ~clk;

   warp_coalesce_unit u_warp_coalesce_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_store(req_store), .req_mask(req_mask), .req_addr(req_addr),
      .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_whole(txn_whole),
      .txn_store(txn_store), .txn_addr(txn_addr), .txn_mask(txn_mask),
      .txn_tid(txn_tid));

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   endtask

   // downstream backpressure
   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1 txn_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
   end

   // driver: computes the expected transactions and offers the request
   task automatic send(input logic st, input logic [31:0] m);
      int          low;
      logic [31:0] base;
      logic        whole;
      exp_t        e;
      low = -1;
      for (int i = 0; i < 32; i++) if (m[i] && low < 0) low = i;
      @(posedge clk); #1;
      req_valid = 1'b1;
      req_store = st;
      req_mask  = m;
      for (int i = 0; i < 32; i++) req_addr[i*AW +: AW] = av[i];
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
      if (low >= 0) begin
         base  = av[low] - 32'(low);
         whole = 1'b1;
         for (int i = 0; i < 32; i++) if (m[i] && av[i] != base + 32'(i)) whole = 1'b0;
         if (whole) begin
            e = '{whole: 1'b1, store: st, addr: base, mask: m, tid: 5'(low)};
            q.push_back(e); pushed++;
         end else begin
            for (int i = 0; i < 32; i++) if (m[i]) begin
               e = '{whole: 1'b0, store: st, addr: av[i], mask: 32'd1 << i, tid: 5'(i)};
               q.push_back(e); pushed++;
            end
         end
      end
   endtask

   // monitor: pops and compares at mid-cycle
   bit   prev_stall = 1'b0;
   exp_t prev_got;
   always @(negedge clk) if (rst_n) begin
      exp_t got, e;
      string tag;
      got = '{whole: txn_whole, store: txn_store, addr: txn_addr, mask: txn_mask, tid: txn_tid};
      if (q.size() > 0) begin
         chks++;
         if (req_ready) begin
            errs++; $display("FAIL R7: req_ready=%0b expected 0 while busy", req_ready);
         end
      end
      if (prev_stall) begin
         chks++;
         if (!txn_valid || got != prev_got) begin
            errs++; $display("FAIL R8: got %h expected held %h", got, prev_got);
         end
      end
      prev_stall = txn_valid && !txn_ready;
      prev_got   = got;
      if (txn_valid && txn_ready) begin
         chks++;
         if (q.size() == 0) begin
            errs++; $display("FAIL R6: unexpected transaction %h, expected none", got);
         end else begin
            e = q.pop_front(); popped++;
            tag = e.whole ? "R3" : "R4";
            if (got.whole != e.whole) begin
               errs++; $display("FAIL R2: whole=%0b expected %0b", got.whole, e.whole);
            end else if (got.store != e.store) begin
               errs++; $display("FAIL R5: store=%0b expected %0b", got.store, e.store);
            end else if (got != e) begin
               errs++; $display("FAIL %s: got %h expected %h", tag, got, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++; chks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   task automatic wait_drain();
      int n = 0;
      while ((q.size() > 0 || txn_valid) && n < 2000) begin
         @(negedge clk); n++;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #0;
      rst_n = 1'b1;
      @(negedge clk);
      chks++;
      if (!req_ready || txn_valid) begin
         errs++; $display("FAIL R1: ready=%0b valid=%0b expected 1/0", req_ready, txn_valid);
      end

      // R2 R3: full warp, ascending words, read
      for (int i = 0; i < 32; i++) av[i] = 32'h100 + 32'(i);
      send(1'b0, 32'hFFFF_FFFF);
      // R2 R5: sparse mask, junk on inactive threads, write
      for (int i = 0; i < 32; i++) av[i] = (i % 8 < 4) ? 32'hDEAD_0000 + 32'(i * 7) : 32'h2000 + 32'(i);
      send(1'b1, 32'hF0F0_F0F0);
      // R2: base wraps below zero
      for (int i = 0; i < 32; i++) av[i] = 32'(i) - 32'd3;
      send(1'b0, 32'h0000_01E0);
      // R4: stride of four words
      for (int i = 0; i < 32; i++) av[i] = 32'(i * 4);
      send(1'b0, 32'hFFFF_FFFF);
      // R4: one wrong thread
      for (int i = 0; i < 32; i++) av[i] = 32'h300 + 32'(i);
      av[17] = 32'h0;
      send(1'b1, 32'hFFFF_FFFF);
      // R4: descending run
      for (int i = 0; i < 32; i++) av[i] = 32'h500 - 32'(i);
      send(1'b0, 32'h0000_00FF);
      // R4 R5: outermost threads only, scatter
      for (int i = 0; i < 32; i++) av[i] = 32'h55;
      av[0] = 32'd10; av[31] = 32'd99;
      send(1'b1, 32'h8000_0001);
      // R3: lone highest thread
      av[31] = 32'h40;
      send(1'b0, 32'h8000_0000);
      wait_drain();

      // R6: empty request
      send(1'b1, 32'h0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chks++;
         if (!req_ready || txn_valid) begin
            errs++; $display("FAIL R6: ready=%0b valid=%0b expected 1/0", req_ready, txn_valid);
         end
      end

      // R7 R8: back-to-back under backpressure
      bp_on = 1'b1;
      for (int i = 0; i < 32; i++) av[i] = 32'h7000 + 32'(i * 3);
      send(1'b0, 32'h0000_F00F);
      for (int i = 0; i < 32; i++) av[i] = 32'h9000 + 32'(i);
      send(1'b1, 32'h0FF0_0000);
      send(1'b0, 32'h0);
      for (int i = 0; i < 32; i++) av[i] = 32'(i * 2);
      send(1'b1, 32'h0000_0006);
      wait_drain();
      bp_on = 1'b0;
      repeat (3) @(negedge clk);

      chks++;
      if (pushed != popped || q.size() != 0) begin
         errs++; $display("FAIL R3: transactions seen=%0d expected %0d", popped, pushed);
      end
      finish_run();
   end
endmodule